// File: doc/BRIEF.md
# Call, Jump and Stack Sequencer

This block owns the program counter and the stack pointer of a small 8-bit controller core. A decoder hands it one control-flow request at a time. Supported requests are absolute call, absolute jump, short relative jump, compare-and-branch, return, return-from-interrupt, push and pop. With each request come the upper opcode bits, up to two operand bytes and the two compare values. The block works out the next PC. It also moves return addresses and pushed or popped bytes through a single byte-wide port into a 256-byte stack RAM.

The RAM performs one access per clock. A call or a return therefore takes two clocks of stack traffic, and a push or a pop takes one. While stack traffic is in progress, `busy` is high and new requests are ignored. Jumps and compare-and-branch use no RAM and finish at the edge that accepts them.

The RAM read is asynchronous: `ramRdData` must show the byte at `ramAddr` in the same cycle. A completed return-from-interrupt raises a one-cycle `isrRelease` pulse, which lets the interrupt logic take further requests at the level it was serving.

Top module: `cjs_sequencer`

## Requirements
- R1: After reset the PC is 0000h, SP is 07h, `busy` is 0, and neither `ramWe` nor `ramRe` is asserted.
- R2: An absolute call (reqOp 1) forms ret = PC+2. It writes ret[7:0] to SP+1 and then, on the next clock, ret[15:8] to SP+2. SP ends 2 higher, and PC ends at {ret[15:11], opcodeHi[2:0], operandA}.
- R3: An absolute jump (reqOp 2) loads PC with {(PC+2)[15:11], opcodeHi, operandA} at the accepting edge, with no RAM access and no `busy`.
- R4: A short jump (reqOp 3) loads PC+2 plus the sign-extended operandA at the accepting edge. A displacement of FEh leaves the PC unchanged.
- R5: Compare-and-branch (reqOp 4) loads PC+3, plus the sign-extended operandB only when cmpLeft differs from cmpRight. In the next cycle `carryValid` pulses, with `carryFlag` = (cmpLeft < cmpRight, unsigned).
- R6: A return (reqOp 5) reads the PC high byte at SP and then the low byte at SP-1. PC becomes {high, low} and SP ends 2 lower.
- R7: Return-from-interrupt (reqOp 6) behaves as R6. In addition, `isrRelease` is high for exactly one cycle, the cycle after the low-byte read; a plain return never raises it.
- R8: A push (reqOp 7) writes operandA to SP+1 and leaves SP incremented by one.
- R9: A pop (reqOp 8) reads the byte at SP. In the next cycle `popValid` is high with that byte on `popData`. SP ends one lower, or, when `popToSp` was set with the request, SP ends equal to the popped byte.
- R10: SP arithmetic wraps modulo 256: a push at SP = FFh writes address 00h, and a pop at SP = 00h leaves SP = FFh.
- R11: `busy` is high for exactly 2 cycles for a call or return, 1 for a push or pop and 0 for a jump. A request presented while `busy` is high has no effect on PC, SP or RAM.
- R12: `ramWe` and `ramRe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 4 | Request code (1 call, 2 jump, 3 short jump, 4 compare-branch, 5 return, 6 interrupt return, 7 push, 8 pop) |
| opcodeHi | input | 3 | Upper three bits of the opcode byte (page bits of absolute targets) |
| operandA | input | 8 | Second instruction byte: page offset, displacement or push data |
| operandB | input | 8 | Third instruction byte: compare-branch displacement |
| cmpLeft | input | 8 | First compare operand |
| cmpRight | input | 8 | Second compare operand |
| popToSp | input | 1 | Pop destination is the stack pointer |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Stack transfer in progress; requests ignored |
| carryValid | output | 1 | One-cycle pulse: carryFlag is fresh |
| carryFlag | output | 1 | Compare result (left below right) |
| popValid | output | 1 | One-cycle pulse: popData is fresh |
| popData | output | 8 | Popped byte |
| isrRelease | output | 1 | One-cycle pulse after an interrupt return |
| ramAddr | output | 8 | Stack RAM address |
| ramWe | output | 1 | Stack RAM write enable |
| ramRe | output | 1 | Stack RAM read enable |
| ramWrData | output | 8 | Stack RAM write data |
| ramRdData | input | 8 | Stack RAM read data (same-cycle) |

## Verification
Jumps and compare-and-branch update `pc` and the carry pulse at the edge that accepts them. They are sampled at the next falling edge. A call or return keeps `busy` high for two cycles, and a push or pop for one. The final PC, SP, RAM bytes, `popValid`/`popData` and `isrRelease` are all due at the first falling edge where `busy` is low again. The bench counts the busy cycles from the accepting edge to that point, compares the count with the expected length, and samples every result there, against a bench-side stack model. Requests driven while `busy` is high are held until that same edge, so their lack of effect is seen in the same samples.

// File: rtl/cjs_pkg.sv
package cjs_pkg;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_ACALL = 4'd1,
    OP_AJMP  = 4'd2,
    OP_SJMP  = 4'd3,
    OP_CJNE  = 4'd4,
    OP_RET   = 4'd5,
    OP_RETI  = 4'd6,
    OP_PUSH  = 4'd7,
    OP_POP   = 4'd8
  } flowOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALL_LO,
    ST_CALL_HI,
    ST_RET_HI,
    ST_RET_LO,
    ST_PUSH,
    ST_POP
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic jumpAbs;
    logic jumpRel;
    logic jumpCmp;
    logic latchCall;
    logic latchPush;
    logic ramWr;
    logic ramRd;
    logic selHi;
    logic wrPush;
    logic spInc;
    logic spDec;
    logic spLoad;
    logic latchHi;
    logic loadTarget;
    logic loadRet;
    logic popDone;
    logic retiDone;
  } strobe_t;

endpackage

// File: rtl/cjs_ctrl.sv
module cjs_ctrl
  import cjs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqOp,
  input  logic       popToSp,
  output strobe_t    strb,
  output logic       busy
);

  seqState_e state;
  seqState_e stateNxt;
  flowOp_e   op;
  logic      accept;
  logic      retiQ;
  logic      popSpQ;

  assign op     = flowOp_e'(reqOp);
  assign busy   = (state != ST_IDLE);
  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          case (op)
            OP_ACALL: begin
              strb.latchCall = 1'b1;
              stateNxt       = ST_CALL_LO;
            end
            OP_AJMP:  strb.jumpAbs = 1'b1;
            OP_SJMP:  strb.jumpRel = 1'b1;
            OP_CJNE:  strb.jumpCmp = 1'b1;
            OP_RET, OP_RETI: stateNxt = ST_RET_HI;
            OP_PUSH: begin
              strb.latchPush = 1'b1;
              stateNxt       = ST_PUSH;
            end
            OP_POP:   stateNxt = ST_POP;
            default:  stateNxt = ST_IDLE;
          endcase
        end
      end
      ST_CALL_LO: begin
        strb.ramWr = 1'b1;
        strb.spInc = 1'b1;
        stateNxt   = ST_CALL_HI;
      end
      ST_CALL_HI: begin
        strb.ramWr      = 1'b1;
        strb.selHi      = 1'b1;
        strb.spInc      = 1'b1;
        strb.loadTarget = 1'b1;
        stateNxt        = ST_IDLE;
      end
      ST_RET_HI: begin
        strb.ramRd   = 1'b1;
        strb.latchHi = 1'b1;
        strb.spDec   = 1'b1;
        stateNxt     = ST_RET_LO;
      end
      ST_RET_LO: begin
        strb.ramRd    = 1'b1;
        strb.loadRet  = 1'b1;
        strb.spDec    = 1'b1;
        strb.retiDone = retiQ;
        stateNxt      = ST_IDLE;
      end
      ST_PUSH: begin
        strb.ramWr  = 1'b1;
        strb.wrPush = 1'b1;
        strb.spInc  = 1'b1;
        stateNxt    = ST_IDLE;
      end
      ST_POP: begin
        strb.ramRd   = 1'b1;
        strb.popDone = 1'b1;
        strb.spDec   = !popSpQ;
        strb.spLoad  = popSpQ;
        stateNxt     = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      retiQ  <= 1'b0;
      popSpQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        retiQ  <= (op == OP_RETI);
        popSpQ <= popToSp;
      end
    end
  end

  // R12: one stack access per clock
  a_r12_one_access: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ramWr, strb.ramRd}));

  // R3: jumps never start stack traffic
  a_r3_jump_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (op == OP_AJMP || op == OP_SJMP || op == OP_CJNE)) |=> !busy);

  // R11: a return occupies exactly two busy cycles
  a_r11_ret_length: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RET_HI) |=> busy ##1 !busy);

  // R11: a call occupies exactly two busy cycles
  a_r11_call_length: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CALL_LO) |=> busy ##1 !busy);

endmodule

// File: rtl/cjs_datapath.sv
module cjs_datapath
  import cjs_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int DATA_W   = 8,
  parameter int PG_W     = 3,
  parameter logic [DATA_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [PG_W-1:0]   opcodeHi,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [DATA_W-1:0] cmpLeft,
  input  logic [DATA_W-1:0] cmpRight,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [PC_W-1:0]   pc,
  output logic [DATA_W-1:0] sp,
  output logic              carryValid,
  output logic              carryFlag,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic              isrRelease,
  output logic [DATA_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [DATA_W-1:0] ramWrData
);

  localparam int PAGE_W = PG_W + DATA_W;
  localparam int EXT_W  = PC_W - DATA_W;

  logic [PC_W-1:0]   pcInc2;
  logic [PC_W-1:0]   pcInc3;
  logic [PC_W-1:0]   absTarget;
  logic [PC_W-1:0]   relA;
  logic [PC_W-1:0]   relB;
  logic [PC_W-1:0]   retQ;
  logic [PC_W-1:0]   tgtQ;
  logic [DATA_W-1:0] hiQ;
  logic [DATA_W-1:0] pushQ;
  logic [DATA_W-1:0] spUp;
  logic [DATA_W-1:0] spDown;

  assign pcInc2    = pc + PC_W'(2);
  assign pcInc3    = pc + PC_W'(3);
  assign absTarget = {pcInc2[PC_W-1:PAGE_W], opcodeHi, operandA};
  assign relA      = {{EXT_W{operandA[DATA_W-1]}}, operandA};
  assign relB      = {{EXT_W{operandB[DATA_W-1]}}, operandB};
  assign spUp      = sp + DATA_W'(1);
  assign spDown    = sp - DATA_W'(1);

  // stack RAM port: writes go to the pre-incremented slot, reads to SP
  assign ramWe     = strb.ramWr;
  assign ramRe     = strb.ramRd;
  assign ramAddr   = strb.ramWr ? spUp : sp;

  always_comb begin
    if (strb.wrPush)     ramWrData = pushQ;
    else if (strb.selHi) ramWrData = retQ[PC_W-1:PC_W-DATA_W];
    else                 ramWrData = retQ[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
    end else if (strb.jumpAbs) begin
      pc <= absTarget;
    end else if (strb.jumpRel) begin
      pc <= pcInc2 + relA;
    end else if (strb.jumpCmp) begin
      pc <= (cmpLeft != cmpRight) ? (pcInc3 + relB) : pcInc3;
    end else if (strb.loadTarget) begin
      pc <= tgtQ;
    end else if (strb.loadRet) begin
      pc <= {hiQ, ramRdData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= SP_RESET;
    end else if (strb.spLoad) begin
      sp <= ramRdData;
    end else if (strb.spInc) begin
      sp <= spUp;
    end else if (strb.spDec) begin
      sp <= spDown;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retQ  <= '0;
      tgtQ  <= '0;
      hiQ   <= '0;
      pushQ <= '0;
    end else begin
      if (strb.latchCall) begin
        retQ <= pcInc2;
        tgtQ <= absTarget;
      end
      if (strb.latchPush) pushQ <= operandA;
      if (strb.latchHi)   hiQ   <= ramRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      carryValid <= 1'b0;
      carryFlag  <= 1'b0;
      popValid   <= 1'b0;
      popData    <= '0;
      isrRelease <= 1'b0;
    end else begin
      carryValid <= strb.jumpCmp;
      if (strb.jumpCmp) carryFlag <= (cmpLeft < cmpRight);
      popValid   <= strb.popDone;
      if (strb.popDone) popData <= ramRdData;
      isrRelease <= strb.retiDone;
    end
  end

  // R8: every write step moves SP up by exactly one
  a_r8_sp_up: assert property (@(posedge clk) disable iff (!rstN)
    strb.spInc |=> (sp == $past(spUp)));

  // R6: every return/pop read step moves SP down by one
  a_r6_sp_down: assert property (@(posedge clk) disable iff (!rstN)
    strb.spDec |=> (sp == $past(spDown)));

  // R9: pop into SP leaves the popped byte in SP
  a_r9_pop_to_sp: assert property (@(posedge clk) disable iff (!rstN)
    strb.spLoad |=> (sp == $past(ramRdData)));

  // R2: call lands inside the 2 KB block of the return address
  a_r2_same_block: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTarget |=> (pc[PC_W-1:PAGE_W] == $past(retQ[PC_W-1:PAGE_W])));

  // R7: release is a single-cycle pulse
  a_r7_release_pulse: assert property (@(posedge clk) disable iff (!rstN)
    isrRelease |=> !isrRelease);

endmodule

// File: rtl/cjs_sequencer.sv
module cjs_sequencer
  import cjs_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int PG_W   = 3,
  parameter logic [DATA_W-1:0] SP_RESET = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [3:0]        reqOp,
  input  logic [PG_W-1:0]   opcodeHi,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic [DATA_W-1:0] cmpLeft,
  input  logic [DATA_W-1:0] cmpRight,
  input  logic              popToSp,
  output logic [PC_W-1:0]   pc,
  output logic [DATA_W-1:0] sp,
  output logic              busy,
  output logic              carryValid,
  output logic              carryFlag,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic              isrRelease,
  output logic [DATA_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [DATA_W-1:0] ramRdData
);

  strobe_t strb;

  cjs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .popToSp  (popToSp),
    .strb     (strb),
    .busy     (busy)
  );

  cjs_datapath #(
    .PC_W     (PC_W),
    .DATA_W   (DATA_W),
    .PG_W     (PG_W),
    .SP_RESET (SP_RESET)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .opcodeHi   (opcodeHi),
    .operandA   (operandA),
    .operandB   (operandB),
    .cmpLeft    (cmpLeft),
    .cmpRight   (cmpRight),
    .ramRdData  (ramRdData),
    .pc         (pc),
    .sp         (sp),
    .carryValid (carryValid),
    .carryFlag  (carryFlag),
    .popValid   (popValid),
    .popData    (popData),
    .isrRelease (isrRelease),
    .ramAddr    (ramAddr),
    .ramWe      (ramWe),
    .ramRe      (ramRe),
    .ramWrData  (ramWrData)
  );

  // R1: no stack access while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(ramWe || ramRe));

endmodule

// File: tb/cjs_sequencer_tb.sv
module cjs_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqOp = '0;
  logic [2:0]  opcodeHi = '0;
  logic [7:0]  operandA = '0;
  logic [7:0]  operandB = '0;
  logic [7:0]  cmpLeft = '0;
  logic [7:0]  cmpRight = '0;
  logic        popToSp = 1'b0;
  logic [15:0] pc;
  logic [7:0]  sp;
  logic        busy, carryValid, carryFlag, popValid, isrRelease;
  logic [7:0]  popData, ramAddr, ramWrData, ramRdData;
  logic        ramWe, ramRe;

  logic [7:0]  mem    [256];
  logic [7:0]  shadow [256];
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;
  bit          bothSeen = 1'b0;
  logic [15:0] expPc;
  logic [7:0]  expSp;

  always #2 clk = ~clk;

  cjs_sequencer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .opcodeHi(opcodeHi), .operandA(operandA), .operandB(operandB),
    .cmpLeft(cmpLeft), .cmpRight(cmpRight), .popToSp(popToSp),
    .pc(pc), .sp(sp), .busy(busy), .carryValid(carryValid),
    .carryFlag(carryFlag), .popValid(popValid), .popData(popData),
    .isrRelease(isrRelease), .ramAddr(ramAddr), .ramWe(ramWe),
    .ramRe(ramRe), .ramWrData(ramWrData), .ramRdData(ramRdData)
  );

  assign ramRdData = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWrData;
  always @(negedge clk) if (rstN && ramWe && ramRe) bothSeen = 1'b1;

  function automatic logic [15:0] sext(input logic [7:0] d);
    return {{8{d[7]}}, d};
  endfunction

  function automatic logic [15:0] absTgt(input logic [15:0] base, input logic [2:0] hi,
                                         input logic [7:0] lo);
    return {base[15:11], hi, lo};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // issue one request and check all results at the first idle negedge
  task automatic doOp(input logic [3:0] op, input logic [2:0] opc, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] l, input logic [7:0] r,
                      input bit toSp, input bit poke, input string tag);
    logic [15:0] ePc;
    logic [15:0] ret;
    logic [7:0]  eSp, hi, lo, v, wa1, wa2;
    int          eBusy, nBusy, nWr;
    bit          eCv, eCf, ePv, eIsr;
    logic [7:0]  ePd;
    ePc = expPc; eSp = expSp; eBusy = 0; eCv = 0; eCf = 0; ePv = 0; eIsr = 0;
    ePd = '0; nWr = 0; wa1 = '0; wa2 = '0;
    case (op)
      4'd1: begin
        ret = expPc + 16'd2;
        wa1 = expSp + 8'd1; wa2 = expSp + 8'd2; nWr = 2;
        shadow[wa1] = ret[7:0]; shadow[wa2] = ret[15:8];
        eSp = wa2; ePc = absTgt(ret, opc, a); eBusy = 2;
      end
      4'd2: ePc = absTgt(expPc + 16'd2, opc, a);
      4'd3: ePc = expPc + 16'd2 + sext(a);
      4'd4: begin
        ePc = expPc + 16'd3 + ((l != r) ? sext(b) : 16'd0);
        eCv = 1; eCf = (l < r);
      end
      4'd5, 4'd6: begin
        hi = shadow[expSp]; lo = shadow[expSp - 8'd1];
        ePc = {hi, lo}; eSp = expSp - 8'd2; eBusy = 2; eIsr = (op == 4'd6);
      end
      4'd7: begin
        wa1 = expSp + 8'd1; nWr = 1; shadow[wa1] = a; eSp = wa1; eBusy = 1;
      end
      default: begin
        v = shadow[expSp]; eSp = toSp ? v : expSp - 8'd1;
        ePv = 1; ePd = v; eBusy = 1;
      end
    endcase
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; opcodeHi = opc; operandA = a; operandB = b;
    cmpLeft = l; cmpRight = r; popToSp = toSp;
    @(negedge clk);
    if (poke && busy) begin
      reqOp = 4'd2; opcodeHi = 3'($urandom); operandA = 8'($urandom); popToSp = 1'b0;
    end else begin
      reqValid = 1'b0;
    end
    nBusy = 0;
    while (busy && nBusy < 8) begin
      nBusy++;
      @(negedge clk);
    end
    reqValid = 1'b0;
    chk(nBusy == eBusy, {tag, " R11 busy cycles"}, nBusy, eBusy);
    chk(pc == ePc, {tag, " pc"}, pc, ePc);
    chk(sp == eSp, {tag, " sp"}, sp, eSp);
    chk(carryValid == eCv, {tag, " R5 carryValid"}, carryValid, eCv);
    if (eCv) chk(carryFlag == eCf, {tag, " R5 carryFlag"}, carryFlag, eCf);
    chk(popValid == ePv, {tag, " R9 popValid"}, popValid, ePv);
    if (ePv) chk(popData == ePd, {tag, " R9 popData"}, popData, ePd);
    chk(isrRelease == eIsr, {tag, " R7 isrRelease"}, isrRelease, eIsr);
    if (nWr >= 1) chk(mem[wa1] == shadow[wa1], {tag, " ram first write"}, mem[wa1], shadow[wa1]);
    if (nWr >= 2) chk(mem[wa2] == shadow[wa2], {tag, " ram second write"}, mem[wa2], shadow[wa2]);
    @(negedge clk);
    if (eIsr) chk(isrRelease == 1'b0, {tag, " R7 pulse width"}, isrRelease, 0);
    expPc = ePc; expSp = eSp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(pc == 16'h0000, "R1 reset pc", pc, 16'h0000);
    chk(sp == 8'h07, "R1 reset sp", sp, 8'h07);
    chk(!busy && !ramWe && !ramRe, "R1 reset idle", {busy, ramWe, ramRe}, 0);
    expPc = 16'h0000; expSp = 8'h07;

    doOp(4'd2, 3'b001, 8'h23, 0, 0, 0, 0, 0, "R3 abs jump");
    chk(pc == 16'h0123, "R3 jump to 0123", pc, 16'h0123);
    doOp(4'd1, 3'b011, 8'h45, 0, 0, 0, 0, 1, "R2 call with ignored request");
    chk(pc == 16'h0345 && sp == 8'h09, "R2 call pc/sp", {pc, sp}, {16'h0345, 8'h09});
    chk(mem[8'h08] == 8'h25 && mem[8'h09] == 8'h01, "R2 return bytes",
        {mem[8'h08], mem[8'h09]}, 16'h2501);
    doOp(4'd5, 0, 0, 0, 0, 0, 0, 1, "R6 return");
    chk(pc == 16'h0125 && sp == 8'h07, "R6 return pc/sp", {pc, sp}, {16'h0125, 8'h07});
    doOp(4'd3, 0, 8'hFE, 0, 0, 0, 0, 0, "R4 self loop");
    chk(pc == 16'h0125, "R4 FE displacement", pc, 16'h0125);
    doOp(4'd3, 0, 8'h10, 0, 0, 0, 0, 0, "R4 forward");
    doOp(4'd3, 0, 8'h80, 0, 0, 0, 0, 0, "R4 backward");
    doOp(4'd4, 0, 0, 8'h10, 8'h34, 8'h34, 0, 0, "R5 equal");
    doOp(4'd4, 0, 0, 8'hF0, 8'h10, 8'h60, 0, 0, "R5 less");
    doOp(4'd4, 0, 0, 8'h05, 8'h90, 8'h20, 0, 0, "R5 greater");
    doOp(4'd7, 0, 8'hFF, 0, 0, 0, 0, 0, "R8 push");
    doOp(4'd8, 0, 0, 0, 0, 0, 1, 1, "R9 pop to sp");
    chk(sp == 8'hFF, "R9 sp from pop", sp, 8'hFF);
    doOp(4'd7, 0, 8'h5A, 0, 0, 0, 0, 1, "R10 push wrap");
    chk(mem[8'h00] == 8'h5A && sp == 8'h00, "R10 wrap to 00", {mem[8'h00], sp}, 16'h5A00);
    doOp(4'd8, 0, 0, 0, 0, 0, 0, 0, "R10 pop wrap");
    chk(sp == 8'hFF, "R10 pop to FF", sp, 8'hFF);
    doOp(4'd6, 0, 0, 0, 0, 0, 0, 0, "R7 interrupt return");

    for (int k = 0; k < 400; k++) begin
      logic [3:0] op;
      op = 4'(1 + ($urandom % 8));
      doOp(op, 3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom % 4),
           8'($urandom % 4), 1'($urandom), 1'($urandom), "random");
    end

    for (int i = 0; i < 256; i++)
      if (mem[i] != shadow[i]) chk(0, "R8 ram image", mem[i], shadow[i]);
    chk(!bothSeen, "R12 read and write together", bothSeen, 0);
    done = 1'b1;
    finishRun();
  end

endmodule